// File: doc/BRIEF.md
# Nested Save-Frame Controller for Enclave Thread Entry and Exit

This block manages the stack of state save frames that belongs to one enclave thread control structure. It takes four kinds of events: a normal enter, a resume after an asynchronous exit, a normal exit, and an asynchronous exit. For each one it decides whether the event is legal, updates its frame index, busy flag and stored exit vector, and returns one response. The response gives the save-frame address to write or read, the next instruction pointer and a link value.

The frame array base, the number of frames and the enclave entry point are static configuration inputs. They are held stable while the structure is in use. An asynchronous exit saves state into the current frame, moves the index up by one and vectors to the exit pointer recorded at the last enter or resume. So asynchronous exits nest when the caller re-enters. A resume pops the most recent frame and marks that frame for reading. The copy of register state is done elsewhere. This block only produces the addresses and decisions.

Top module: `sfc_exit_frame_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, busy is 0, frame_index is 0 and rsp_valid is 0.
- R2: An enter (cmd_op = 0) is accepted when busy is 0 and frame_index is below cfg_frame_count. It sets busy, leaves frame_index unchanged and stores cmd_exit_ptr as the exit vector. It responds with rsp_next_ip = cfg_entry_ip, rsp_link = cmd_arg and rsp_frame_op = 0 (none).
- R3: An enter is rejected when busy is 1 or when frame_index equals cfg_frame_count. Any rejected command leaves busy, frame_index and the exit vector unchanged. Its response has rsp_ok = 0 and zero frame op, address, next IP and link.
- R4: An asynchronous exit (cmd_op = 3) while busy is accepted. It responds with rsp_frame_op = 1 (save) at address cfg_frame_base + frame_index × FRAME_BYTES and with rsp_next_ip equal to the stored exit vector. It then increments frame_index and clears busy.
- R5: A normal exit or an asynchronous exit while busy is 0 is rejected.
- R6: After an asynchronous exit, a new enter is accepted, and a further asynchronous exit saves into the next frame, at an address higher by FRAME_BYTES.
- R7: A resume (cmd_op = 1) is accepted when busy is 0 and frame_index is non-zero. It responds with rsp_frame_op = 2 (load) at cfg_frame_base + (frame_index − 1) × FRAME_BYTES and rsp_next_ip = 0. It decrements frame_index, sets busy and stores cmd_exit_ptr as the new exit vector.
- R8: A resume is rejected when frame_index is 0 or busy is 1.
- R9: A normal exit (cmd_op = 2) while busy is accepted. It responds with rsp_next_ip = cmd_arg and frame op none, clears busy and leaves frame_index unchanged.
- R10: Every command gets exactly one response. The response is presented with rsp_valid high in the cycle after cmd_valid, and rsp_valid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_frame_base | input | ADDR_W | Address of save frame 0 |
| cfg_frame_count | input | IDX_W | Number of save frames available |
| cfg_entry_ip | input | ADDR_W | Enclave entry point used by enter |
| cmd_valid | input | 1 | Command strobe, one cycle per event |
| cmd_op | input | 2 | 0 enter, 1 resume, 2 normal exit, 3 asynchronous exit |
| cmd_arg | input | ADDR_W | Enter: return address; normal exit: target address |
| cmd_exit_ptr | input | ADDR_W | Exit vector supplied with enter or resume |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | 1 accepted, 0 rejected |
| rsp_frame_op | output | 2 | 0 none, 1 save, 2 load |
| rsp_frame_addr | output | ADDR_W | Save-frame address for the frame op |
| rsp_next_ip | output | ADDR_W | Next instruction pointer |
| rsp_link | output | ADDR_W | Link value returned by enter |
| busy | output | 1 | Structure currently in use by a thread |
| frame_index | output | IDX_W | Current save-frame index |

## Verification
The bench first tries every event in a state where it is illegal: exits while idle, a resume at index zero, an enter or resume while busy, and an enter when all frames are used. A controller with a loose legality check would accept one of these and move the index or the busy flag. The bench then nests two and three asynchronous exits and resumes between them. A design that used the wrong index for the save or load address would report a frame one slot off. A design that kept the first exit vector instead of the newest one would vector a later asynchronous exit to a stale address. The bench also checks that a normal exit keeps the frame index, which a design that treated it like an asynchronous exit would break.

// File: rtl/sfc_pkg.sv
// Shared encodings for the save-frame controller.
// Assumes two-bit command and frame-operation fields on the ports.
package sfc_pkg;

    typedef enum logic [1:0] {
        OP_ENTER  = 2'd0,
        OP_RESUME = 2'd1,
        OP_EXIT   = 2'd2,
        OP_ASYNC  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FOP_NONE = 2'd0,
        FOP_SAVE = 2'd1,
        FOP_LOAD = 2'd2
    } fop_e;

endpackage

// File: rtl/sfc_frame_addr.sv
// Save-frame address generator: base + index * FRAME_BYTES.
// A power-of-two frame size becomes a shift; any other size uses a multiplier.
// Assumes the product fits in ADDR_W bits.
module sfc_frame_addr #(
    parameter int ADDR_W      = 48,
    parameter int IDX_W       = 4,
    parameter int FRAME_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] addr
);
    localparam int FRAME_LOG = $clog2(FRAME_BYTES);
    localparam bit IS_POW2   = ((1 << FRAME_LOG) == FRAME_BYTES);

    logic [ADDR_W-1:0] offset;

    generate
        if (IS_POW2) begin : g_shift
            // Offset by shifting the index into the frame-size bit position
            assign offset = ADDR_W'(index) << FRAME_LOG;
        end else begin : g_mult
            // Offset by a full multiply for frame sizes that are not powers of two
            assign offset = ADDR_W'(index) * ADDR_W'(FRAME_BYTES);
        end
    endgenerate

    // Final address is the array base plus the frame offset
    assign addr = base + offset;
endmodule

// File: rtl/sfc_event_decode.sv
// Event legality and next-state decision for one thread control structure.
// Purely combinational. Assumes cfg count is stable while the structure is busy.
module sfc_event_decode #(
    parameter int IDX_W = 4
) (
    input  logic             valid,
    input  sfc_pkg::op_e     op,
    input  logic             busy,
    input  logic [IDX_W-1:0] index,
    input  logic [IDX_W-1:0] count,
    output logic             accept,
    output logic             busy_nx,
    output logic [IDX_W-1:0] index_nx,
    output sfc_pkg::fop_e    fop,
    output logic             sel_prev,
    output logic             rec_ptr
);
    import sfc_pkg::*;

    logic legal;

    // Legality of the requested event against the current structure state
    always_comb begin
        unique case (op)
            OP_ENTER:  legal = !busy && (index < count);
            OP_RESUME: legal = !busy && (index != '0);
            OP_EXIT:   legal = busy;
            default:   legal = busy;
        endcase
    end

    assign accept = valid && legal;

    // Next-state values and side effects for an accepted event
    always_comb begin
        busy_nx  = busy;
        index_nx = index;
        fop      = FOP_NONE;
        sel_prev = 1'b0;
        rec_ptr  = 1'b0;
        if (accept) begin
            unique case (op)
                OP_ENTER: begin
                    busy_nx = 1'b1;
                    rec_ptr = 1'b1;
                end
                OP_RESUME: begin
                    busy_nx  = 1'b1;
                    index_nx = index - IDX_W'(1);
                    fop      = FOP_LOAD;
                    sel_prev = 1'b1;
                    rec_ptr  = 1'b1;
                end
                OP_EXIT: begin
                    busy_nx = 1'b0;
                end
                default: begin
                    busy_nx  = 1'b0;
                    index_nx = index + IDX_W'(1);
                    fop      = FOP_SAVE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sfc_thread_state.sv
// Per-structure state: busy flag, save-frame index and recorded exit vector.
// Synchronous active-low reset; updates only on accepted events.
module sfc_thread_state #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy_nx,
    input  logic [IDX_W-1:0]  index_nx,
    input  logic              rec_ptr,
    input  logic [ADDR_W-1:0] new_ptr,
    output logic              busy,
    output logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] exit_ptr
);
    // Busy flag and index follow the decoder on accepted events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            index <= '0;
        end else if (accept) begin
            busy  <= busy_nx;
            index <= index_nx;
        end
    end

    // Exit vector captured on accepted enter or resume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_ptr <= '0;
        end else if (accept && rec_ptr) begin
            exit_ptr <= new_ptr;
        end
    end
endmodule

// File: rtl/sfc_exit_frame_ctrl.sv
// Top: nested save-frame controller for one enclave thread control structure.
// One command per cycle in, one registered response per command out, one cycle later.
// Assumes cfg inputs are stable while busy or while frames are in use.
module sfc_exit_frame_ctrl #(
    parameter int ADDR_W      = 48,
    parameter int IDX_W       = 4,
    parameter int FRAME_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_frame_base,
    input  logic [IDX_W-1:0]  cfg_frame_count,
    input  logic [ADDR_W-1:0] cfg_entry_ip,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_arg,
    input  logic [ADDR_W-1:0] cmd_exit_ptr,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [1:0]        rsp_frame_op,
    output logic [ADDR_W-1:0] rsp_frame_addr,
    output logic [ADDR_W-1:0] rsp_next_ip,
    output logic [ADDR_W-1:0] rsp_link,
    output logic              busy,
    output logic [IDX_W-1:0]  frame_index
);
    import sfc_pkg::*;

    op_e               op;
    logic              accept;
    logic              busy_nx;
    logic [IDX_W-1:0]  index_nx;
    fop_e              fop;
    logic              sel_prev;
    logic              rec_ptr;
    logic [ADDR_W-1:0] exit_ptr;
    logic [IDX_W-1:0]  addr_index;
    logic [ADDR_W-1:0] frame_addr;
    logic [ADDR_W-1:0] next_ip;
    logic [ADDR_W-1:0] link;

    assign op = op_e'(cmd_op);

    sfc_event_decode #(.IDX_W(IDX_W)) u_decode (
        .valid    (cmd_valid),
        .op       (op),
        .busy     (busy),
        .index    (frame_index),
        .count    (cfg_frame_count),
        .accept   (accept),
        .busy_nx  (busy_nx),
        .index_nx (index_nx),
        .fop      (fop),
        .sel_prev (sel_prev),
        .rec_ptr  (rec_ptr)
    );

    sfc_thread_state #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .busy_nx  (busy_nx),
        .index_nx (index_nx),
        .rec_ptr  (rec_ptr),
        .new_ptr  (cmd_exit_ptr),
        .busy     (busy),
        .index    (frame_index),
        .exit_ptr (exit_ptr)
    );

    // Resume reads the frame below the current index; a save uses the current one
    assign addr_index = sel_prev ? (frame_index - IDX_W'(1)) : frame_index;

    sfc_frame_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FRAME_BYTES(FRAME_BYTES)) u_addr (
        .base  (cfg_frame_base),
        .index (addr_index),
        .addr  (frame_addr)
    );

    // Next instruction pointer and link value for an accepted event
    always_comb begin
        next_ip = '0;
        link    = '0;
        if (accept) begin
            unique case (op)
                OP_ENTER: begin
                    next_ip = cfg_entry_ip;
                    link    = cmd_arg;
                end
                OP_EXIT:  next_ip = cmd_arg;
                OP_ASYNC: next_ip = exit_ptr;
                default:  next_ip = '0;
            endcase
        end
    end

    // Registered response, one per command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_ok         <= 1'b0;
            rsp_frame_op   <= FOP_NONE;
            rsp_frame_addr <= '0;
            rsp_next_ip    <= '0;
            rsp_link       <= '0;
        end else begin
            rsp_valid      <= cmd_valid;
            rsp_ok         <= accept;
            rsp_frame_op   <= fop;
            rsp_frame_addr <= (fop != FOP_NONE) ? frame_addr : '0;
            rsp_next_ip    <= next_ip;
            rsp_link       <= link;
        end
    end
endmodule

// File: rtl/sfc_exit_frame_checker.sv
// Protocol checker for the save-frame controller, attached by bind.
// Observes only top-level ports.
module sfc_exit_frame_checker #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  cfg_frame_count,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_arg,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [ADDR_W-1:0] rsp_next_ip,
    input logic              busy,
    input logic [IDX_W-1:0]  frame_index
);
    // R1: reset clears state and response strobe
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!busy && frame_index == '0 && !rsp_valid));

    // R10: exactly one response per command, one cycle later
    a_r10_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R3: a busy structure always has a free frame to save into
    a_r3_busy_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (frame_index < cfg_frame_count));

    // R4: accepted asynchronous exit bumps the index and clears busy
    a_r4_async_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3 && busy)
        |=> (rsp_ok && !busy && frame_index == $past(frame_index) + IDX_W'(1)));

    // R5: exits while idle are refused
    a_r5_idle_exit_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1] && !busy) |=> (rsp_valid && !rsp_ok && !busy));

    // R7: accepted resume pops one frame and marks busy
    a_r7_resume_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && !busy && frame_index != '0)
        |=> (rsp_ok && busy && frame_index == $past(frame_index) - IDX_W'(1)));

    // R8: resume at index zero is refused and changes nothing
    a_r8_resume_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && frame_index == '0)
        |=> (!rsp_ok && frame_index == '0 && busy == $past(busy)));

    // R9: normal exit returns to the caller's address and keeps the index
    a_r9_exit_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && busy)
        |=> (!busy && frame_index == $past(frame_index) && rsp_next_ip == $past(cmd_arg)));
endmodule

bind sfc_exit_frame_ctrl sfc_exit_frame_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_frame_count (cfg_frame_count),
    .cmd_valid       (cmd_valid),
    .cmd_op          (cmd_op),
    .cmd_arg         (cmd_arg),
    .rsp_valid       (rsp_valid),
    .rsp_ok          (rsp_ok),
    .rsp_next_ip     (rsp_next_ip),
    .busy            (busy),
    .frame_index     (frame_index)
);

// File: tb/sfc_exit_frame_ctrl_bench.sv
// Scoreboard bench: driver pushes expected responses, monitor pops and compares.
module sfc_exit_frame_ctrl_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 32;
    localparam int IDX_W       = 3;
    localparam int FRAME_BYTES = 4096;

    localparam logic [ADDR_W-1:0] BASE  = 32'h1000_0000;
    localparam logic [ADDR_W-1:0] ENTRY = 32'h4000_0100;
    localparam logic [IDX_W-1:0]  COUNT = 3'd3;

    typedef struct {
        logic              ok;
        logic [1:0]        fop;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nip;
        logic [ADDR_W-1:0] link;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [ADDR_W-1:0] cmd_arg = '0;
    logic [ADDR_W-1:0] cmd_exit_ptr = '0;
    logic              rsp_valid, rsp_ok, busy;
    logic [1:0]        rsp_frame_op;
    logic [ADDR_W-1:0] rsp_frame_addr, rsp_next_ip, rsp_link;
    logic [IDX_W-1:0]  frame_index;

    int compared = 0;
    int mismatched = 0;
    exp_t exp_q[$];

    logic              m_busy = 1'b0;
    logic [IDX_W-1:0]  m_idx = '0;
    logic [ADDR_W-1:0] m_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfc_exit_frame_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FRAME_BYTES(FRAME_BYTES)) u_sfc_exit_frame_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_frame_base(BASE), .cfg_frame_count(COUNT), .cfg_entry_ip(ENTRY),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_exit_ptr(cmd_exit_ptr),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_frame_op(rsp_frame_op),
        .rsp_frame_addr(rsp_frame_addr), .rsp_next_ip(rsp_next_ip), .rsp_link(rsp_link),
        .busy(busy), .frame_index(frame_index)
    );

    task automatic check(input string req, input string what, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: model the expected response from the requirements, push it, drive one cycle
    task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] arg,
                         input logic [ADDR_W-1:0] ptr, input string req);
        exp_t e;
        e.ok = 1'b0; e.fop = 2'd0; e.addr = '0; e.nip = '0; e.link = '0; e.req = req;
        case (op)
            2'd0: if (!m_busy && m_idx < COUNT) begin
                e.ok = 1'b1; e.nip = ENTRY; e.link = arg;
                m_busy = 1'b1; m_ptr = ptr;
            end
            2'd1: if (!m_busy && m_idx != 0) begin
                e.ok = 1'b1; e.fop = 2'd2;
                e.addr = BASE + ADDR_W'(m_idx - 3'd1) * FRAME_BYTES;
                m_idx = m_idx - 3'd1; m_busy = 1'b1; m_ptr = ptr;
            end
            2'd2: if (m_busy) begin
                e.ok = 1'b1; e.nip = arg; m_busy = 1'b0;
            end
            default: if (m_busy) begin
                e.ok = 1'b1; e.fop = 2'd1;
                e.addr = BASE + ADDR_W'(m_idx) * FRAME_BYTES;
                e.nip = m_ptr; m_idx = m_idx + 3'd1; m_busy = 1'b0;
            end
        endcase
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_exit_ptr = ptr;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_arg = '0; cmd_exit_ptr = '0;
        check(req, "busy", ADDR_W'(busy), ADDR_W'(m_busy));
        check(req, "frame_index", ADDR_W'(frame_index), ADDR_W'(m_idx));
    endtask

    // Monitor: pop the oldest expected response and compare field by field
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "rsp_ok", ADDR_W'(rsp_ok), ADDR_W'(e.ok));
                check(e.req, "rsp_frame_op", ADDR_W'(rsp_frame_op), ADDR_W'(e.fop));
                check(e.req, "rsp_frame_addr", rsp_frame_addr, e.addr);
                check(e.req, "rsp_next_ip", rsp_next_ip, e.nip);
                check(e.req, "rsp_link", rsp_link, e.link);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 20000);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", ADDR_W'(busy), 0);
        check("R1", "rsp_valid in reset", ADDR_W'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "frame_index after reset", ADDR_W'(frame_index), 0);
        check("R10", "rsp_valid idle", ADDR_W'(rsp_valid), 0);

        issue(2'd2, 32'h0000_0777, '0, "R5");            // exit while idle
        issue(2'd3, '0, '0, "R5");                       // async exit while idle
        issue(2'd1, '0, 32'h0000_0C00, "R8");            // resume at index 0
        issue(2'd0, 32'h0000_0500, 32'h0000_0A00, "R2"); // enter
        issue(2'd0, 32'h0000_0600, 32'h0000_0F00, "R3"); // enter while busy
        issue(2'd1, '0, 32'h0000_0F00, "R8");            // resume while busy
        issue(2'd3, '0, '0, "R4");                       // async exit, frame 0
        issue(2'd0, 32'h0000_0510, 32'h0000_0B00, "R6"); // re-enter
        issue(2'd3, '0, '0, "R6");                       // nested save, frame 1
        issue(2'd1, '0, 32'h0000_0C00, "R7");            // resume pops frame 1
        issue(2'd3, '0, '0, "R7");                       // vectors to new pointer
        issue(2'd0, 32'h0000_0520, 32'h0000_0D00, "R2");
        issue(2'd3, '0, '0, "R4");                       // frame 2, index now 3
        issue(2'd0, 32'h0000_0530, 32'h0000_0E00, "R3"); // all frames used
        issue(2'd1, '0, 32'h0000_0C40, "R7");            // pops frame 2
        issue(2'd2, 32'h0000_0777, '0, "R9");            // normal exit keeps index
        issue(2'd1, '0, 32'h0000_0C80, "R7");            // pops frame 1
        issue(2'd2, 32'h0000_0888, '0, "R9");

        repeat (2) @(negedge clk);
        check("R10", "responses outstanding", ADDR_W'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule